// File: doc/BRIEF.md
# ROM Entry List Walker

This block traverses the chain of variable-length records stored after the fixed header of a device configuration ROM image. The image sits in a byte-wide buffer with a synchronous read port. The walker begins at the first record after the header and moves from record to record, using each record's own length byte to find the next one. It stops when it reaches the image size taken from the header length field. Records of the generic kind are stepped over. For each record that describes a port, the walker reports the port's number, whether the port is switched off, its link lane and its dual-link partner, as one record strobe.

Before it decodes a record for an enabled port, the walker asks an outside agent whether that port is really a normal data port. It raises a request carrying the port number and waits for an acknowledge that brings the answer. Malformed chains end the walk early, with an error flag raised alongside the completion strobe. Records already reported before the fault stay valid.

Top module: `rom_entry_walker`

## Requirements
- R1: While reset is held, `walk_done`, `walk_error`, `rec_valid`, `mem_rd_en` and `ptype_req` are all low.
- R2: A pulse on `start` while idle sets the image size to `data_len` + 13 and the first record offset to 22. If 22 is not below the size, the walk ends with `walk_done` and no error, having emitted no record.
- R3: Byte 0 of a record is its length. In byte 1, bits 5:0 are the port number, bit 6 is the switched-off flag and bit 7 is the kind (1 = port, 0 = generic). The next record starts at the current offset plus the length. The walk ends cleanly when that offset reaches the image size.
- R4: A generic record emits no record strobe and raises no port-type request.
- R5: A port record with bit 6 set emits one record with `rec_disabled`=1 and with link, dual and partner all zero. It raises no port-type request.
- R6: An enabled port record raises `ptype_req`, with `ptype_idx` equal to its port number, and holds it until `ptype_ack`. If `ptype_is_port` is 0, the record is emitted with `rec_disabled`, `rec_link`, `rec_has_dual` and `rec_partner` all zero.
- R7: When `ptype_is_port` is 1, the record length must be exactly 8 bytes, and any other length ends the walk with an error. Bit 4 of byte 2 gives `rec_link` and bit 7 of byte 2 gives `rec_has_dual`. `rec_partner` is bits 5:0 of byte 3 when `rec_has_dual` is 1, and 0 otherwise.
- R8: The walk ends with `walk_done` and `walk_error` both high, and emits no further record, if any of these holds: a length byte is zero, offset plus length exceeds the image size, or offset plus 1 equals the image size.
- R9: `walk_done` is a one-cycle pulse. Records are emitted in chain order, each as a one-cycle `rec_valid`. `walk_error` stays at its last value until the next accepted `start` clears it.
- R10: Every buffer read addresses a byte below the image size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| data_len | input | LEN_W | Header length field; image size is this plus 13 |
| mem_rd_en | output | 1 | Buffer read enable |
| mem_rd_addr | output | ADDR_W | Buffer byte address |
| mem_rd_data | input | 8 | Buffer data, one cycle after the read enable |
| ptype_req | output | 1 | Port-type query request |
| ptype_idx | output | 6 | Port number being queried |
| ptype_ack | input | 1 | Query answer strobe |
| ptype_is_port | input | 1 | Answer: 1 when the port is a normal data port |
| rec_valid | output | 1 | Port record strobe |
| rec_index | output | 6 | Port number |
| rec_disabled | output | 1 | Port switched off |
| rec_link | output | 1 | Link lane number |
| rec_has_dual | output | 1 | Dual-link partner present |
| rec_partner | output | 6 | Dual-link partner port number |
| walk_done | output | 1 | Walk finished strobe |
| walk_error | output | 1 | Walk ended on a malformed chain |

## Verification
The properties assume that the buffer returns the addressed byte exactly one cycle after each read enable. They also assume that `ptype_ack` is a single-cycle pulse given only while `ptype_req` is high, and that `data_len` does not change during a walk. The bench meets these conditions as follows. It models the buffer as a registered array. Its query responder acknowledges only a raised request, after a chosen delay, and drops the acknowledge on the next cycle. It changes `data_len` only before it pulses `start`.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;

    localparam int unsigned ENTRY_BASE       = 22;
    localparam int unsigned IMAGE_BIAS       = 13;
    localparam int unsigned PORT_ENTRY_BYTES = 8;
    localparam int unsigned PORT_ID_W        = 6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_LEN,
        S_HDR,
        S_QUERY,
        S_BYTE2,
        S_BYTE3,
        S_EMIT,
        S_FINISH
    } walk_state_e;

    typedef enum logic [1:0] {
        SEL_LEN = 2'd0,
        SEL_HDR = 2'd1,
        SEL_B2  = 2'd2,
        SEL_B3  = 2'd3
    } byte_sel_e;

    typedef struct packed {
        logic [PORT_ID_W-1:0] index;
        logic                 disabled;
        logic                 link;
        logic                 has_dual;
        logic [PORT_ID_W-1:0] partner;
    } port_rec_t;

    function automatic logic hdr_is_port(input logic [7:0] b);
        return b[7];
    endfunction

    function automatic logic hdr_is_off(input logic [7:0] b);
        return b[6];
    endfunction

    function automatic logic [PORT_ID_W-1:0] hdr_port_id(input logic [7:0] b);
        return b[PORT_ID_W-1:0];
    endfunction

    function automatic logic lane_bit(input logic [7:0] b);
        return b[4];
    endfunction

    function automatic logic dual_bit(input logic [7:0] b);
        return b[7];
    endfunction

    function automatic logic [PORT_ID_W-1:0] partner_id(input logic [7:0] b);
        return b[PORT_ID_W-1:0];
    endfunction

endpackage

// File: rtl/rwalk_cursor.sv
module rwalk_cursor
    import rwalk_pkg::*;
#(
    parameter int unsigned LEN_W = 10,
    parameter int unsigned POS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] data_len,
    input  logic             take_len,
    input  logic [7:0]       len_byte,
    input  logic             advance,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] size,
    output logic             at_end,
    output logic             tail_fault,
    output logic             len_fault,
    output logic             len_is_port
);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] size_q;
    logic [7:0]       len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            size_q <= '0;
            len_q  <= '0;
        end else begin
            if (load) begin
                pos_q  <= POS_W'(ENTRY_BASE);
                size_q <= POS_W'(data_len) + POS_W'(IMAGE_BIAS);
            end else if (advance) begin
                pos_q <= pos_q + POS_W'(len_q);
            end
            if (take_len) begin
                len_q <= len_byte;
            end
        end
    end

    assign pos         = pos_q;
    assign size        = size_q;
    assign at_end      = (pos_q >= size_q);
    assign tail_fault  = ((pos_q + POS_W'(1)) == size_q);
    assign len_fault   = (len_byte == 8'd0) || ((pos_q + POS_W'(len_byte)) > size_q);
    assign len_is_port = (len_q == 8'(PORT_ENTRY_BYTES));

    AST_POS_FORWARD: assert property (@(posedge clk) disable iff (rst)
        advance |=> (pos_q > $past(pos_q)));  // R3

endmodule

// File: rtl/rwalk_decoder.sv
module rwalk_decoder
    import rwalk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap_hdr,
    input  logic      cap_b2,
    input  logic      cap_b3,
    input  logic [7:0] byte_in,
    output port_rec_t rec
);

    port_rec_t rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (cap_hdr) begin
            rec_q          <= '0;
            rec_q.index    <= hdr_port_id(byte_in);
            rec_q.disabled <= hdr_is_off(byte_in);
        end else if (cap_b2) begin
            rec_q.link     <= lane_bit(byte_in);
            rec_q.has_dual <= dual_bit(byte_in);
        end else if (cap_b3) begin
            rec_q.partner  <= rec_q.has_dual ? partner_id(byte_in) : '0;
        end
    end

    assign rec = rec_q;

    AST_PARTNER_GATED: assert property (@(posedge clk) disable iff (rst)
        (rec_q.partner != '0) |-> rec_q.has_dual);  // R7

endmodule

// File: rtl/rwalk_ctrl.sv
module rwalk_ctrl
    import rwalk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      at_end,
    input  logic      tail_fault,
    input  logic      len_fault,
    input  logic      len_is_port,
    input  logic      hdr_port,
    input  logic      hdr_off,
    input  logic      ptype_ack,
    input  logic      ptype_is_port,
    output logic      load,
    output logic      take_len,
    output logic      cap_hdr,
    output logic      cap_b2,
    output logic      cap_b3,
    output logic      advance,
    output logic      rd_en,
    output byte_sel_e rd_sel,
    output logic      ptype_req,
    output logic      rec_valid,
    output logic      walk_done,
    output logic      walk_error
);

    walk_state_e state_q, state_d;
    logic        err_q;
    logic        err_set;

    always_comb begin
        state_d   = state_q;
        err_set   = 1'b0;
        load      = 1'b0;
        take_len  = 1'b0;
        cap_hdr   = 1'b0;
        cap_b2    = 1'b0;
        cap_b3    = 1'b0;
        advance   = 1'b0;
        rd_en     = 1'b0;
        rd_sel    = SEL_LEN;
        ptype_req = 1'b0;
        rec_valid = 1'b0;
        walk_done = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = S_CHECK;
                end
            end
            S_CHECK: begin
                if (at_end) begin
                    state_d = S_FINISH;
                end else if (tail_fault) begin
                    err_set = 1'b1;
                    state_d = S_FINISH;
                end else begin
                    rd_en   = 1'b1;
                    rd_sel  = SEL_LEN;
                    state_d = S_LEN;
                end
            end
            S_LEN: begin
                take_len = 1'b1;
                if (len_fault) begin
                    err_set = 1'b1;
                    state_d = S_FINISH;
                end else begin
                    rd_en   = 1'b1;
                    rd_sel  = SEL_HDR;
                    state_d = S_HDR;
                end
            end
            S_HDR: begin
                cap_hdr = 1'b1;
                if (!hdr_port) begin
                    advance = 1'b1;
                    state_d = S_CHECK;
                end else if (hdr_off) begin
                    state_d = S_EMIT;
                end else begin
                    state_d = S_QUERY;
                end
            end
            S_QUERY: begin
                ptype_req = 1'b1;
                if (ptype_ack) begin
                    if (!ptype_is_port) begin
                        state_d = S_EMIT;
                    end else if (!len_is_port) begin
                        err_set = 1'b1;
                        state_d = S_FINISH;
                    end else begin
                        rd_en   = 1'b1;
                        rd_sel  = SEL_B2;
                        state_d = S_BYTE2;
                    end
                end
            end
            S_BYTE2: begin
                cap_b2  = 1'b1;
                rd_en   = 1'b1;
                rd_sel  = SEL_B3;
                state_d = S_BYTE3;
            end
            S_BYTE3: begin
                cap_b3  = 1'b1;
                state_d = S_EMIT;
            end
            S_EMIT: begin
                rec_valid = 1'b1;
                advance   = 1'b1;
                state_d   = S_CHECK;
            end
            S_FINISH: begin
                walk_done = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                err_q <= 1'b0;
            end else if (err_set) begin
                err_q <= 1'b1;
            end
        end
    end

    assign walk_error = err_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (ptype_req && !ptype_ack) |=> ptype_req);  // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done);  // R9
    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(walk_error) |-> walk_done);  // R8
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rec_valid, walk_done, ptype_req}));  // R9

endmodule

// File: rtl/rom_entry_walker.sv
module rom_entry_walker
    import rwalk_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  data_len,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              ptype_req,
    output logic [5:0]        ptype_idx,
    input  logic              ptype_ack,
    input  logic              ptype_is_port,
    output logic              rec_valid,
    output logic [5:0]        rec_index,
    output logic              rec_disabled,
    output logic              rec_link,
    output logic              rec_has_dual,
    output logic [5:0]        rec_partner,
    output logic              walk_done,
    output logic              walk_error
);

    localparam int unsigned POS_W = $clog2((1 << LEN_W) + IMAGE_BIAS + 256);

    logic [POS_W-1:0] pos, size;
    logic             at_end, tail_fault, len_fault, len_is_port;
    logic             load, take_len, cap_hdr, cap_b2, cap_b3, advance;
    byte_sel_e        rd_sel;
    port_rec_t        rec;

    rwalk_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .at_end       (at_end),
        .tail_fault   (tail_fault),
        .len_fault    (len_fault),
        .len_is_port  (len_is_port),
        .hdr_port     (hdr_is_port(mem_rd_data)),
        .hdr_off      (hdr_is_off(mem_rd_data)),
        .ptype_ack    (ptype_ack),
        .ptype_is_port(ptype_is_port),
        .load         (load),
        .take_len     (take_len),
        .cap_hdr      (cap_hdr),
        .cap_b2       (cap_b2),
        .cap_b3       (cap_b3),
        .advance      (advance),
        .rd_en        (mem_rd_en),
        .rd_sel       (rd_sel),
        .ptype_req    (ptype_req),
        .rec_valid    (rec_valid),
        .walk_done    (walk_done),
        .walk_error   (walk_error)
    );

    rwalk_cursor #(
        .LEN_W(LEN_W),
        .POS_W(POS_W)
    ) u_cursor (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .data_len   (data_len),
        .take_len   (take_len),
        .len_byte   (mem_rd_data),
        .advance    (advance),
        .pos        (pos),
        .size       (size),
        .at_end     (at_end),
        .tail_fault (tail_fault),
        .len_fault  (len_fault),
        .len_is_port(len_is_port)
    );

    rwalk_decoder u_decoder (
        .clk    (clk),
        .rst    (rst),
        .cap_hdr(cap_hdr),
        .cap_b2 (cap_b2),
        .cap_b3 (cap_b3),
        .byte_in(mem_rd_data),
        .rec    (rec)
    );

    assign mem_rd_addr  = ADDR_W'(pos + POS_W'(rd_sel));
    assign ptype_idx    = rec.index;
    assign rec_index    = rec.index;
    assign rec_disabled = rec.disabled;
    assign rec_link     = rec.link;
    assign rec_has_dual = rec.has_dual;
    assign rec_partner  = rec.partner;

    AST_READ_IN_IMAGE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> ((pos + POS_W'(rd_sel)) < size));  // R10
    AST_OFF_PORT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_disabled) |-> (!rec_link && !rec_has_dual && rec_partner == '0));  // R5

endmodule

// File: tb/test_rom_entry_walker.sv
module test_rom_entry_walker;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int LEN_W      = 10;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  data_len = '0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [7:0]        mem_rd_data = 8'd0;
    logic              ptype_req;
    logic [5:0]        ptype_idx;
    logic              ptype_ack = 1'b0;
    logic              ptype_is_port = 1'b0;
    logic              rec_valid;
    logic [5:0]        rec_index;
    logic              rec_disabled, rec_link, rec_has_dual;
    logic [5:0]        rec_partner;
    logic              walk_done, walk_error;

    logic [7:0]  mem [0:(1<<ADDR_W)-1];
    logic [63:0] port_map = '0;
    int          ack_delay = 0;
    int          resp_cnt = 0;
    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;
    int          exp_size = 0;
    logic [14:0] exp_rec[$];
    logic [5:0]  exp_qry[$];
    logic        exp_err = 1'b0;
    bit          case_done = 1'b0;
    bit          active = 1'b0;
    bit          req_seen = 1'b0;
    bit          prev_done = 1'b0;
    string       tag = "";

    rom_entry_walker i_rom_entry_walker (
        .clk(clk), .rst(rst), .start(start), .data_len(data_len),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .ptype_req(ptype_req), .ptype_idx(ptype_idx), .ptype_ack(ptype_ack),
        .ptype_is_port(ptype_is_port), .rec_valid(rec_valid), .rec_index(rec_index),
        .rec_disabled(rec_disabled), .rec_link(rec_link), .rec_has_dual(rec_has_dual),
        .rec_partner(rec_partner), .walk_done(walk_done), .walk_error(walk_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = 8'd0;
        port_map = '0;
    endtask

    // Reference walk over the bench memory, written from the requirements
    task automatic build_expect();
        int pos, size, len;
        logic [7:0] b1, b2, b3;
        exp_rec.delete();
        exp_qry.delete();
        exp_err = 1'b0;
        size = int'(data_len) + 13;
        exp_size = size;
        pos = 22;
        while (pos < size) begin
            if (pos + 1 == size) begin exp_err = 1'b1; break; end
            len = int'(mem[pos]);
            if (len == 0 || pos + len > size) begin exp_err = 1'b1; break; end
            b1 = mem[pos+1];
            if (b1[7]) begin
                if (b1[6]) begin
                    exp_rec.push_back({b1[5:0], 1'b1, 8'd0});
                end else begin
                    exp_qry.push_back(b1[5:0]);
                    if (!port_map[b1[5:0]]) begin
                        exp_rec.push_back({b1[5:0], 9'd0});
                    end else if (len != 8) begin
                        exp_err = 1'b1;
                        break;
                    end else begin
                        b2 = mem[pos+2];
                        b3 = mem[pos+3];
                        exp_rec.push_back({b1[5:0], 1'b0, b2[4], b2[7], (b2[7] ? b3[5:0] : 6'd0)});
                    end
                end
            end
            pos += len;
        end
    endtask

    // Port-type responder
    initial begin
        forever begin
            @(negedge clk);
            if (ptype_ack) begin
                ptype_ack = 1'b0;
                ptype_is_port = 1'b0;
            end else if (ptype_req) begin
                if (resp_cnt >= ack_delay) begin
                    ptype_ack = 1'b1;
                    ptype_is_port = port_map[ptype_idx];
                    resp_cnt = 0;
                end else begin
                    resp_cnt++;
                end
            end
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (active) begin
            if (mem_rd_en) check("R10", "read address in image", 32'(int'(mem_rd_addr) < exp_size), 1);
            if (ptype_req && !req_seen) begin
                if (exp_qry.size() == 0) check(tag, "unexpected port-type request", 1, 0);
                else check(tag, "query port number", 32'(ptype_idx), 32'(exp_qry.pop_front()));
            end
            req_seen = ptype_req;
            if (rec_valid) begin
                if (exp_rec.size() == 0) check(tag, "unexpected record", 32'({rec_index, rec_disabled, rec_link, rec_has_dual, rec_partner}), 32'h7fff_ffff);
                else check(tag, "record fields", 32'({rec_index, rec_disabled, rec_link, rec_has_dual, rec_partner}), 32'(exp_rec.pop_front()));
            end
            if (walk_done) begin
                check("R9", "done is one cycle", 32'(prev_done), 0);
                check(tag, "error flag at done", 32'(walk_error), 32'(exp_err));
                check(tag, "records outstanding", 32'(exp_rec.size()), 0);
                check(tag, "queries outstanding", 32'(exp_qry.size()), 0);
                case_done = 1'b1;
            end
            prev_done = walk_done;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog %s actual=%0d cycles expected<=%0d", tag, cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_case(string req, int dl, int dly);
        tag = req;
        data_len = dl[LEN_W-1:0];
        ack_delay = dly;
        resp_cnt = 0;
        build_expect();
        case_done = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "error cleared by start", 32'(walk_error), 0);
        while (!case_done) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fill_mixed();
        clear_mem();
        mem[22] = 8'd5;  mem[23] = 8'h03;                               // generic
        mem[27] = 8'd8;  mem[28] = 8'hC1; mem[29] = 8'hFF; mem[30] = 8'hFF; // port 1 off
        mem[35] = 8'd8;  mem[36] = 8'h82; mem[37] = 8'h90; mem[38] = 8'hC3; // port 2 dual -> 3
        mem[43] = 8'd8;  mem[44] = 8'h83; mem[45] = 8'h10; mem[46] = 8'h2A; // port 3 lane 1, no dual
        mem[51] = 8'd6;  mem[52] = 8'h84; mem[53] = 8'hFF;                  // port 4 not a data port
        mem[57] = 8'd16; mem[58] = 8'h00;                                   // generic to end
        port_map[2] = 1'b1;
        port_map[3] = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "done in reset", 32'(walk_done), 0);
        check("R1", "error in reset", 32'(walk_error), 0);
        check("R1", "record strobe in reset", 32'(rec_valid), 0);
        check("R1", "read enable in reset", 32'(mem_rd_en), 0);
        check("R1", "request in reset", 32'(ptype_req), 0);
        rst = 1'b0;
        active = 1'b1;
        @(negedge clk);

        clear_mem();
        run_case("R2", 9, 0);

        fill_mixed();
        run_case("R3 R4 R5 R6 R7", 60, 2);
        run_case("R6", 60, 0);
        run_case("R6", 60, 5);

        clear_mem();
        mem[22] = 8'd0;
        run_case("R8", 20, 0);

        clear_mem();
        mem[22] = 8'd8; mem[23] = 8'h85; mem[24] = 8'h10; mem[25] = 8'h00;
        mem[30] = 8'd5; mem[31] = 8'h00;
        port_map[5] = 1'b1;
        run_case("R8", 20, 1);

        clear_mem();
        mem[22] = 8'd10; mem[23] = 8'h00;
        run_case("R8", 20, 0);

        clear_mem();
        mem[22] = 8'd9; mem[23] = 8'h86; mem[24] = 8'h90; mem[25] = 8'h01;
        port_map[6] = 1'b1;
        run_case("R7", 27, 1);

        clear_mem();
        mem[22] = 8'd255;  mem[23] = 8'h00;
        mem[277] = 8'd255; mem[278] = 8'h00;
        mem[532] = 8'd255; mem[533] = 8'h00;
        mem[787] = 8'd249; mem[788] = 8'h87;
        mem[789] = 8'h90;  mem[790] = 8'h05;
        run_case("R3", 1023, 0);

        fill_mixed();
        run_case("R9", 60, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule